// File: doc/BRIEF.md
# Dual-Bank Serial Button Reader

This block reads 48 push buttons through two external chains of parallel-in/serial-out shift registers. Each chain holds 24 bits and has its own serial data line into the block. Both chains share one load strobe and one shift clock, so one scan of 24 shift clocks covers all 48 buttons. That is half the length of a single 48-bit chain.

A free-running timer starts a scan every `SCAN_PERIOD` system cycles, which is 10 ms at a 50 MHz system clock by default. Each scan first holds the active-low load strobe for one shift-clock period. It then issues 24 shift clocks and samples both serial lines together just before each rising edge. The shift clock runs at the system clock divided by `2*DIV`, so the slowest external register sets `DIV`. At the end of a scan the block publishes the 48-bit vector with a one-cycle valid pulse. It raises a change flag in the same cycle when the vector differs from the one published before. Buttons are active low: a pressed key reads 0 and a released key reads 1.

Top module: `btn_scan_dual`

## Requirements
- R1: While reset is held, `sr_load_n` is 1, `sr_clk` is 0, `btn_state` is all ones, and `scan_valid` and `scan_changed` are 0.
- R2: Each scan holds `sr_load_n` low for exactly `2*DIV` system cycles with `sr_clk` low, then gives exactly `BANK_BITS` rising edges on `sr_clk` with `sr_load_n` high.
- R3: Every high phase and every low phase of `sr_clk` lasts at least `DIV` system cycles.
- R4: Both serial inputs are sampled in the same system cycle, namely the last cycle of each low phase of `sr_clk`, just before it rises.
- R5: Bank A fills `btn_state[BANK_BITS-1:0]` and bank B fills the upper half. In each half, the first bit shifted out lands at the highest index and the last bit at the lowest index. A 0 means pressed.
- R6: `scan_valid` is a pulse one cycle long, and `btn_state` changes only in a cycle where `scan_valid` is 1.
- R7: `scan_changed` is 1 only together with `scan_valid`, and only when the new vector differs from the previously published one. The value held from reset, all ones, counts as the first previous vector.
- R8: Scans start every `SCAN_PERIOD` cycles, so `scan_valid` pulses are spaced exactly `SCAN_PERIOD` cycles apart. This also holds when the timer tick falls in the last cycle of a scan, with `SCAN_PERIOD` equal to `50*DIV`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sr_load_n | output | 1 | Active-low parallel-load strobe to both chains |
| sr_clk | output | 1 | Shift clock shared by both chains |
| sr_dat_a | input | 1 | Serial data from bank A |
| sr_dat_b | input | 1 | Serial data from bank B |
| btn_state | output | 2*BANK_BITS | Last published button vector, 0 = pressed |
| scan_valid | output | 1 | One-cycle pulse when a new vector is published |
| scan_changed | output | 1 | Vector differs from the previous one (with scan_valid) |

## Verification
The scan-rate tick and the completion of a scan can land in the same system cycle. If the completion logic only restarted from idle, that tick would be lost. The bench sets `SCAN_PERIOD` to exactly the scan length, so every scan ends on the tick that must start the next one. It then judges the case by requiring each valid pulse to follow the previous one by exactly `SCAN_PERIOD` cycles. It also requires the next load window and shift-edge count to stay intact, with every published vector matching its button pattern.

// File: rtl/btn_scan_dual.sv
module btn_scan_dual #(
  parameter int BANK_BITS   = 24,
  parameter int DIV         = 5,
  parameter int SCAN_PERIOD = 500000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  output logic                   sr_load_n,
  output logic                   sr_clk,
  input  logic                   sr_dat_a,
  input  logic                   sr_dat_b,
  output logic [2*BANK_BITS-1:0] btn_state,
  output logic                   scan_valid,
  output logic                   scan_changed
);
  localparam int DW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int BW = (BANK_BITS > 2) ? $clog2(BANK_BITS) : 1;
  localparam int PW = (SCAN_PERIOD > 2) ? $clog2(SCAN_PERIOD) : 1;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_SHIFT} st_t;
  st_t st;

  logic [PW-1:0]        per_cnt;
  logic [DW-1:0]        div_cnt;
  logic [BW-1:0]        bit_cnt;
  logic                 ph;
  logic [BANK_BITS-1:0] sh_a, sh_b;

  wire tick   = per_cnt == PW'(SCAN_PERIOD - 1);
  wire half   = div_cnt == DW'(DIV - 1);
  wire finish = (st == S_SHIFT) && half && ph && (bit_cnt == BW'(BANK_BITS - 1));
  wire start  = tick && ((st == S_IDLE) || finish);

  assign sr_load_n = (st != S_LOAD);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) per_cnt <= '0;
    else        per_cnt <= tick ? '0 : per_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      div_cnt      <= '0;
      bit_cnt      <= '0;
      ph           <= 1'b0;
      sr_clk       <= 1'b0;
      sh_a         <= '1;
      sh_b         <= '1;
      btn_state    <= '1;
      scan_valid   <= 1'b0;
      scan_changed <= 1'b0;
    end else begin
      scan_valid   <= finish;
      scan_changed <= finish && ({sh_b, sh_a} != btn_state);
      if (finish) btn_state <= {sh_b, sh_a};
      div_cnt <= (start || half) ? '0 : div_cnt + 1'b1;
      case (st)
        S_IDLE:
          if (start) begin
            st <= S_LOAD;
            ph <= 1'b0;
          end
        S_LOAD:
          if (half) begin
            ph <= ~ph;
            if (ph) begin
              st      <= S_SHIFT;
              bit_cnt <= '0;
            end
          end
        S_SHIFT:
          if (half) begin
            if (!ph) begin
              sh_a   <= {sh_a[BANK_BITS-2:0], sr_dat_a};
              sh_b   <= {sh_b[BANK_BITS-2:0], sr_dat_b};
              sr_clk <= 1'b1;
              ph     <= 1'b1;
            end else begin
              sr_clk <= 1'b0;
              ph     <= 1'b0;
              if (bit_cnt == BW'(BANK_BITS - 1)) st <= start ? S_LOAD : S_IDLE;
              else                               bit_cnt <= bit_cnt + 1'b1;
            end
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic          clk_d;
  logic [DW:0]   hold_cnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      clk_d    <= 1'b0;
      hold_cnt <= '0;
    end else begin
      clk_d <= sr_clk;
      if (sr_clk != clk_d)                hold_cnt <= '0;
      else if (hold_cnt != (DW+1)'(DIV)) hold_cnt <= hold_cnt + 1'b1;
    end

  p_clk_low_in_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sr_load_n |-> !sr_clk);
  p_min_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_clk != clk_d) |-> (hold_cnt >= (DW+1)'(DIV - 1)));
  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    scan_valid |=> !scan_valid);
  p_state_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_valid |-> $stable(btn_state));
  p_changed_qual_r7: assert property (@(posedge clk) disable iff (!rst_n)
    scan_changed |-> scan_valid);
endmodule

// File: tb/btn_scan_dual_bench.sv
module btn_scan_dual_bench;
  localparam int NB  = 24;
  localparam int DIV = 2;
  localparam int SP  = 50 * DIV;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sr_load_n, sr_clk, sr_dat_a, sr_dat_b, scan_valid, scan_changed;
  logic [2*NB-1:0] btn_state;
  logic [2*NB-1:0] buttons = '1;
  logic [NB-1:0] q_a = '1, q_b = '1;
  int checks = 0, fails = 0;
  int cyc = 0, rises = 0, load_len = 0, last_edge = 0, last_valid = -1;

  always #10 clk = ~clk;

  btn_scan_dual #(.BANK_BITS(NB), .DIV(DIV), .SCAN_PERIOD(SP)) u_btn_scan_dual (
    .clk(clk), .rst_n(rst_n), .sr_load_n(sr_load_n), .sr_clk(sr_clk),
    .sr_dat_a(sr_dat_a), .sr_dat_b(sr_dat_b), .btn_state(btn_state),
    .scan_valid(scan_valid), .scan_changed(scan_changed));

  always @(posedge sr_load_n or posedge sr_clk)
    if (sr_clk) begin
      q_a <= {q_a[NB-2:0], 1'b1};
      q_b <= {q_b[NB-2:0], 1'b1};
    end else begin
      q_a <= buttons[NB-1:0];
      q_b <= buttons[2*NB-1:NB];
    end
  assign sr_dat_a = sr_load_n ? q_a[NB-1] : buttons[NB-1];
  assign sr_dat_b = sr_load_n ? q_b[NB-1] : buttons[2*NB-1];

  task automatic chk(input bit ok, input string req, input logic [2*NB-1:0] act, exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc++;
  always @(posedge sr_clk) rises++;

  logic prev_clk = 1'b0, prev_ld = 1'b1;
  always @(negedge clk) if (rst_n) begin
    if (sr_clk != prev_clk) begin
      chk(cyc - last_edge >= DIV, "R3 phase length", 48'(cyc - last_edge), 48'(DIV));
      last_edge = cyc;
    end
    if (!sr_load_n) begin
      if (prev_ld) rises = 0;
      load_len++;
    end else if (!prev_ld) begin
      chk(load_len == 2 * DIV, "R2 load width", 48'(load_len), 48'(2 * DIV));
      load_len = 0;
    end
    prev_clk = sr_clk;
    prev_ld  = sr_load_n;
  end

  localparam int NV = 9;
  localparam logic [2*NB-1:0] VEC [NV] = '{
    48'hFFFFFF_FFFFFF, 48'hFFFFFF_FFFFFE, 48'hFFFFFF_7FFFFF,
    48'hFFFFFE_FFFFFF, 48'h7FFFFF_FFFFFF, 48'h7FFFFE_FF5A7E,
    48'h7FFFFE_FF5A7E, 48'h123456_89ABCD, 48'h000000_000000};

  task automatic wait_valid(output bit ok);
    ok = 0;
    for (int i = 0; i < 4 * SP; i++) begin
      @(negedge clk);
      if (scan_valid) begin ok = 1; break; end
    end
  endtask

  initial begin
    logic [2*NB-1:0] prev;
    bit ok;
    repeat (3) @(negedge clk);
    chk(sr_load_n === 1'b1 && sr_clk === 1'b0, "R1 strobes", {46'd0, sr_load_n, sr_clk}, 48'd2);
    chk(btn_state === '1, "R1 state", btn_state, '1);
    chk(scan_valid === 1'b0 && scan_changed === 1'b0, "R1 flags", {46'd0, scan_valid, scan_changed}, 48'd0);
    rst_n = 1'b1;
    wait_valid(ok);
    chk(ok, "R8 first scan timeout", 48'(ok), 48'd1);
    last_valid = cyc;
    prev = '1;
    for (int v = 0; v < NV; v++) begin
      buttons = VEC[v];
      @(negedge clk);
      chk(scan_valid === 1'b0, "R6 valid one cycle", 48'(scan_valid), 48'd0);
      wait_valid(ok);
      chk(ok, "R8 scan timeout", 48'(ok), 48'd1);
      chk(cyc - last_valid == SP, "R8 scan spacing", 48'(cyc - last_valid), 48'(SP));
      last_valid = cyc;
      chk(rises == NB, "R2 shift edges", 48'(rises), 48'(NB));
      chk(btn_state[NB-1:0] === VEC[v][NB-1:0], "R5 bank A order", btn_state, VEC[v]);
      chk(btn_state[2*NB-1:NB] === VEC[v][2*NB-1:NB], "R4 R5 bank B order", btn_state, VEC[v]);
      chk(scan_changed === (VEC[v] != prev), "R7 change flag", 48'(scan_changed), 48'(VEC[v] != prev));
      prev = VEC[v];
    end
    buttons = 48'h0F0F0F_F0F0F0;
    for (int i = 0; i < SP / 2; i++) begin
      @(negedge clk);
      chk(btn_state === prev, "R6 state held between pulses", btn_state, prev);
    end
    wait_valid(ok);
    chk(btn_state === 48'h0F0F0F_F0F0F0 && scan_changed, "R7 R5 after hold", btn_state, 48'h0F0F0F_F0F0F0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule